// File: doc/BRIEF.md
# Inclusive Cache Back-Invalidation Sequencer

This block keeps a lower-level cache inclusive of the upper-level cache above it. When the upper level allocates a line whose tag is absent from the lower level, the block takes the directory entry at the request's index as the victim. For every coherency granule of that victim that is still valid, it sends a back-invalidation to the upper level. It collects one response per back-invalidation. A response may carry a push-back of modified data, and that push-back marks the granule Modified in the directory.

Only after every response has arrived does the block decide whether the victim must be written back to memory. It requests that copy-back if it is needed, and then retires the old tag. Next it requests the fetch for the new tag and installs the new tag with the granules being filled. A one-cycle completion pulse ends the sequence. The directory keeps one tag per index and four-state MESI per granule. Data movement and memory timing are handled elsewhere. The allocation port is meant for lower-level misses only.

Top module: `incl_backinv_seq`

## Requirements
- R1: After reset every directory entry is Invalid in all granules and holds tag 0. `alloc_ready` is high, and `binv_valid`, `cb_valid`, `fetch_valid` and `done` are low.
- R2: An allocation is taken only when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` stays low from that edge until the cycle after `done`. An `alloc_valid` raised while busy has no effect on any output.
- R3: The victim is the entry at `alloc_idx`. One back-invalidation is issued for each granule of the victim whose state is not Invalid. They go out in ascending granule order, and each carries the victim tag, the index and the granule number. Invalid granules are skipped.
- R4: If every granule of the victim is Invalid, no back-invalidation and no copy-back is issued. `fetch_valid` rises two cycles after the accepting edge.
- R5: At most one of `binv_valid`, `cb_valid`, `fetch_valid` and `done` is high at a time. Neither `cb_valid` nor `fetch_valid` is raised while an issued back-invalidation still lacks its response.
- R6: A response with `resp_push`=1 marks granule `resp_gran` Modified. A response with `resp_push`=0 leaves the directory state unchanged, so the only effect of a miss is that the response is counted.
- R7: A copy-back is requested if and only if at least one victim granule is Modified once all responses are in. `cb_mask` bit g is set exactly for the Modified granules, and `cb_tag` and `cb_idx` name the victim.
- R8: The fetch request carries the new tag, the index and `alloc_fill`. On its handshake the entry takes the new tag. Granules with a fill bit become Exclusive when `alloc_excl`=1 and Shared when it is 0, and all other granules become Invalid.
- R9: `done` is high for exactly one cycle, the cycle after the fetch handshake.
- R10: Once raised, `binv_valid`, `cb_valid` and `fetch_valid` stay high with stable payload until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Idle, accepting an allocation |
| alloc_idx | input | IDX_W | Directory index of the new line |
| alloc_tag | input | TAG_W | Tag of the new line |
| alloc_excl | input | 1 | Install as Exclusive (1) or Shared (0) |
| alloc_fill | input | GRAN | Granules brought in by the fetch |
| binv_valid | output | 1 | Back-invalidation request |
| binv_ready | input | 1 | Upper level accepts the back-invalidation |
| binv_idx | output | IDX_W | Victim index |
| binv_tag | output | TAG_W | Victim tag |
| binv_gran | output | GW | Granule number |
| resp_valid | input | 1 | Back-invalidation response |
| resp_gran | input | GW | Granule the response belongs to |
| resp_push | input | 1 | 1: hit Modified, push-back returned; 0: miss or clean |
| cb_valid | output | 1 | Copy-back request for the victim |
| cb_ready | input | 1 | Copy-back accepted |
| cb_idx | output | IDX_W | Victim index |
| cb_tag | output | TAG_W | Victim tag |
| cb_mask | output | GRAN | Modified granules to write back |
| fetch_valid | output | 1 | Fetch request for the new tag |
| fetch_ready | input | 1 | Fetch accepted |
| fetch_idx | output | IDX_W | Index of the new line |
| fetch_tag | output | TAG_W | New tag |
| fetch_fill | output | GRAN | Granules being fetched |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches every cycle for the following. The request outputs must be exclusive and quiet while idle. A copy-back or fetch must never start while the checker's own count of back-invalidations still lacks responses. Requests must hold with stable payload under backpressure, a copy-back must always carry a non-empty mask, and `done` must be a single pulse that returns the block to idle. Some properties are visible only in the bench's scenarios, because they depend on directory history that builds up across allocations: which granules are skipped, the exact copy-back mask after a mix of hit and miss responses, the Exclusive or Shared install state as seen by the next victim, and the two-cycle path taken for an Invalid victim.

// File: rtl/incl_pkg.sv
package incl_pkg;

  typedef logic [1:0] mesi_t;
  localparam mesi_t ST_I = 2'd0;
  localparam mesi_t ST_S = 2'd1;
  localparam mesi_t ST_E = 2'd2;
  localparam mesi_t ST_M = 2'd3;

  typedef enum logic [2:0] {
    P_IDLE, P_SELECT, P_BINV, P_WAIT, P_COPYBACK, P_FETCH, P_DONE
  } phase_t;

  function automatic logic is_live(mesi_t s);
    return s != ST_I;
  endfunction

  function automatic logic is_dirty(mesi_t s);
    return s == ST_M;
  endfunction

  function automatic mesi_t fill_state(logic fill, logic excl);
    if (!fill) return ST_I;
    return excl ? ST_E : ST_S;
  endfunction

endpackage

// File: rtl/incl_dir.sv
module incl_dir
  import incl_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int GRAN  = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int GW    = (GRAN > 1) ? $clog2(GRAN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [TAG_W-1:0]          rd_tag,
  output mesi_t [GRAN-1:0]          rd_st,
  input  logic                      mark_en,
  input  logic [GW-1:0]             mark_gran,
  input  logic                      retire_en,
  input  logic                      inst_en,
  input  logic [TAG_W-1:0]          inst_tag,
  input  mesi_t [GRAN-1:0]          inst_st
);

  logic [TAG_W-1:0]      tag_q [SETS];
  logic [GRAN-1:0][1:0]  st_q  [SETS];

  assign rd_tag = tag_q[rd_idx];
  assign rd_st  = st_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= '0;
      end
    end else if (inst_en) begin
      tag_q[rd_idx] <= inst_tag;
      st_q[rd_idx]  <= inst_st;
    end else if (retire_en) begin
      st_q[rd_idx] <= '0;
    end else if (mark_en) begin
      st_q[rd_idx][mark_gran] <= ST_M;
    end
  end

endmodule

// File: rtl/incl_seq_ctl.sv
module incl_seq_ctl
  import incl_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int GRAN  = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int GW    = (GRAN > 1) ? $clog2(GRAN) : 1,
  localparam int CW    = $clog2(GRAN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_excl,
  input  logic [GRAN-1:0]   alloc_fill,
  input  logic              binv_ready,
  input  logic              resp_valid,
  input  logic              resp_push,
  input  logic              cb_ready,
  input  logic              fetch_ready,
  input  logic [GRAN-1:0]   live_mask,
  input  logic [GRAN-1:0]   dirty_mask,
  output logic              alloc_ready,
  output logic              binv_valid,
  output logic              binv_fire,
  output logic              cb_valid,
  output logic              fetch_valid,
  output logic              done,
  output logic              resp_take,
  output logic              mark_en,
  output logic              retire_en,
  output logic              inst_en,
  output logic [GW-1:0]     gran_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [TAG_W-1:0]  ntag_q,
  output logic              excl_q,
  output logic [GRAN-1:0]   fill_q
);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] iss_q, rsp_q;
  logic          cur_live, g_step, g_last, all_back;

  assign cur_live    = live_mask[gran_q];
  assign g_last      = gran_q == GW'(GRAN - 1);
  assign all_back    = iss_q == rsp_q;

  assign alloc_ready = ph_q == P_IDLE;
  assign binv_valid  = (ph_q == P_BINV) && cur_live;
  assign binv_fire   = binv_valid && binv_ready;
  assign g_step      = (ph_q == P_BINV) && (!cur_live || binv_ready);
  assign cb_valid    = ph_q == P_COPYBACK;
  assign fetch_valid = ph_q == P_FETCH;
  assign done        = ph_q == P_DONE;

  assign resp_take   = resp_valid && (ph_q == P_BINV || ph_q == P_WAIT);
  assign mark_en     = resp_take && resp_push;
  assign retire_en   = ((ph_q == P_WAIT) && all_back && (dirty_mask == '0))
                     || (cb_valid && cb_ready);
  assign inst_en     = fetch_valid && fetch_ready;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      P_IDLE:     if (alloc_valid) ph_d = P_SELECT;
      P_SELECT:   ph_d = (live_mask == '0) ? P_FETCH : P_BINV;
      P_BINV:     if (g_step && g_last) ph_d = P_WAIT;
      P_WAIT:     if (all_back) ph_d = (dirty_mask != '0) ? P_COPYBACK : P_FETCH;
      P_COPYBACK: if (cb_ready) ph_d = P_FETCH;
      P_FETCH:    if (fetch_ready) ph_d = P_DONE;
      P_DONE:     ph_d = P_IDLE;
      default:    ph_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= P_IDLE;
      idx_q  <= '0;
      ntag_q <= '0;
      excl_q <= 1'b0;
      fill_q <= '0;
      gran_q <= '0;
      iss_q  <= '0;
      rsp_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (alloc_ready && alloc_valid) begin
        idx_q  <= alloc_idx;
        ntag_q <= alloc_tag;
        excl_q <= alloc_excl;
        fill_q <= alloc_fill;
      end
      if (ph_q == P_SELECT) begin
        gran_q <= '0;
        iss_q  <= '0;
        rsp_q  <= '0;
      end else begin
        if (g_step && !g_last) gran_q <= gran_q + 1'b1;
        if (binv_fire)         iss_q  <= iss_q + 1'b1;
        if (resp_take)         rsp_q  <= rsp_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/incl_backinv_seq.sv
module incl_backinv_seq
  import incl_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int GRAN  = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int GW    = (GRAN > 1) ? $clog2(GRAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_excl,
  input  logic [GRAN-1:0]   alloc_fill,
  output logic              binv_valid,
  input  logic              binv_ready,
  output logic [IDX_W-1:0]  binv_idx,
  output logic [TAG_W-1:0]  binv_tag,
  output logic [GW-1:0]     binv_gran,
  input  logic              resp_valid,
  input  logic [GW-1:0]     resp_gran,
  input  logic              resp_push,
  output logic              cb_valid,
  input  logic              cb_ready,
  output logic [IDX_W-1:0]  cb_idx,
  output logic [TAG_W-1:0]  cb_tag,
  output logic [GRAN-1:0]   cb_mask,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic [TAG_W-1:0]  fetch_tag,
  output logic [GRAN-1:0]   fetch_fill,
  output logic              done
);

  // named internal events, also observed by the bound checker
  logic              evt_binv_fire, evt_resp_take, evt_resp_mark, evt_retire, evt_install;

  logic [GRAN-1:0]   live_mask, dirty_mask;
  mesi_t [GRAN-1:0]  rd_st, inst_st;
  logic [TAG_W-1:0]  rd_tag, ntag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GW-1:0]     gran_q;
  logic              excl_q;
  logic [GRAN-1:0]   fill_q;

  for (genvar g = 0; g < GRAN; g++) begin : g_gran
    assign live_mask[g]  = is_live(rd_st[g]);
    assign dirty_mask[g] = is_dirty(rd_st[g]);
    assign inst_st[g]    = fill_state(fill_q[g], excl_q);
  end

  incl_seq_ctl #(.SETS(SETS), .GRAN(GRAN), .TAG_W(TAG_W)) ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_idx   (alloc_idx),
    .alloc_tag   (alloc_tag),
    .alloc_excl  (alloc_excl),
    .alloc_fill  (alloc_fill),
    .binv_ready  (binv_ready),
    .resp_valid  (resp_valid),
    .resp_push   (resp_push),
    .cb_ready    (cb_ready),
    .fetch_ready (fetch_ready),
    .live_mask   (live_mask),
    .dirty_mask  (dirty_mask),
    .alloc_ready (alloc_ready),
    .binv_valid  (binv_valid),
    .binv_fire   (evt_binv_fire),
    .cb_valid    (cb_valid),
    .fetch_valid (fetch_valid),
    .done        (done),
    .resp_take   (evt_resp_take),
    .mark_en     (evt_resp_mark),
    .retire_en   (evt_retire),
    .inst_en     (evt_install),
    .gran_q      (gran_q),
    .idx_q       (idx_q),
    .ntag_q      (ntag_q),
    .excl_q      (excl_q),
    .fill_q      (fill_q)
  );

  incl_dir #(.SETS(SETS), .GRAN(GRAN), .TAG_W(TAG_W)) dir_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx_q),
    .rd_tag    (rd_tag),
    .rd_st     (rd_st),
    .mark_en   (evt_resp_mark),
    .mark_gran (resp_gran),
    .retire_en (evt_retire),
    .inst_en   (evt_install),
    .inst_tag  (ntag_q),
    .inst_st   (inst_st)
  );

  assign binv_idx   = idx_q;
  assign binv_tag   = rd_tag;
  assign binv_gran  = gran_q;
  assign cb_idx     = idx_q;
  assign cb_tag     = rd_tag;
  assign cb_mask    = dirty_mask;
  assign fetch_idx  = idx_q;
  assign fetch_tag  = ntag_q;
  assign fetch_fill = fill_q;

endmodule

// File: rtl/incl_seq_chk.sv
module incl_seq_chk #(
  parameter int GRAN  = 4,
  parameter int TAG_W = 8,
  parameter int GW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             binv_valid,
  input logic             binv_ready,
  input logic [GW-1:0]    binv_gran,
  input logic             resp_valid,
  input logic             cb_valid,
  input logic             cb_ready,
  input logic [TAG_W-1:0] cb_tag,
  input logic [GRAN-1:0]  cb_mask,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [TAG_W-1:0] fetch_tag,
  input logic             done,
  input logic             evt_resp_mark,
  input logic             evt_install
);

  // outstanding back-invalidations, counted from the ports only
  logic [7:0] outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else outst <= outst + {7'd0, binv_valid && binv_ready} - {7'd0, resp_valid};
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> !(binv_valid || cb_valid || fetch_valid || done)); // R2
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({binv_valid, cb_valid, fetch_valid, done})); // R5
  AST_NO_EARLY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid || fetch_valid) |-> outst == 8'd0); // R5
  AST_MARK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resp_mark |-> outst != 8'd0); // R6
  AST_CB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> cb_mask != '0); // R7
  AST_INSTALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_install |=> done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && alloc_ready)); // R9
  AST_BINV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && !binv_ready) |=> (binv_valid && $stable(binv_gran))); // R10
  AST_CB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && !cb_ready) |=> (cb_valid && $stable(cb_mask) && $stable(cb_tag))); // R10
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_tag))); // R10

endmodule

bind incl_backinv_seq incl_seq_chk #(.GRAN(GRAN), .TAG_W(TAG_W), .GW(GW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_ready   (alloc_ready),
  .binv_valid    (binv_valid),
  .binv_ready    (binv_ready),
  .binv_gran     (binv_gran),
  .resp_valid    (resp_valid),
  .cb_valid      (cb_valid),
  .cb_ready      (cb_ready),
  .cb_tag        (cb_tag),
  .cb_mask       (cb_mask),
  .fetch_valid   (fetch_valid),
  .fetch_ready   (fetch_ready),
  .fetch_tag     (fetch_tag),
  .done          (done),
  .evt_resp_mark (evt_resp_mark),
  .evt_install   (evt_install)
);

// File: tb/incl_backinv_seq_tb.sv
`timescale 1ns/1ps
module incl_backinv_seq_tb_top;

  localparam int SETS = 8, GRAN = 4, TAG_W = 8, IDX_W = 3, GW = 2;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready, alloc_excl = 0;
  logic [IDX_W-1:0] alloc_idx = '0;
  logic [TAG_W-1:0] alloc_tag = '0;
  logic [GRAN-1:0]  alloc_fill = '0;
  logic binv_valid, binv_ready = 0;
  logic [IDX_W-1:0] binv_idx;
  logic [TAG_W-1:0] binv_tag;
  logic [GW-1:0]    binv_gran;
  logic resp_valid = 0, resp_push = 0;
  logic [GW-1:0] resp_gran = '0;
  logic cb_valid, cb_ready = 0;
  logic [IDX_W-1:0] cb_idx;
  logic [TAG_W-1:0] cb_tag;
  logic [GRAN-1:0]  cb_mask;
  logic fetch_valid, fetch_ready = 0;
  logic [IDX_W-1:0] fetch_idx;
  logic [TAG_W-1:0] fetch_tag;
  logic [GRAN-1:0]  fetch_fill;
  logic done;

  incl_backinv_seq #(.SETS(SETS), .GRAN(GRAN), .TAG_W(TAG_W)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  bit run = 0, hung = 0;

  // behavioural reference: phase 0 idle,1 select,2 invalidate,3 collect,4 write back,5 fetch,6 done
  int m_ph = 0, m_g = 0, m_iss = 0, m_ans = 0;
  int m_idx = 0, m_ntag = 0, m_excl = 0, m_fill = 0;
  int m_tag [SETS];
  int m_st  [SETS][GRAN];   // 0 I, 1 S, 2 E, 3 M

  // scenario knobs and request
  bit req_pend = 0, scn_done = 0, k_noise = 0;
  int r_idx, r_tag, r_excl, r_fill, k_gap = 0, k_delay = 1, k_push = 0;
  int rq_due[$], rq_g[$], rq_p[$];
  // tallies seen at the DUT ports
  int d_binv, d_cb, d_cbmask, d_fetch_at, t_acc;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int dmask(int idx);
    int m = 0;
    for (int g = 0; g < GRAN; g++) if (m_st[idx][g] == 3) m |= (1 << g);
    return m;
  endfunction

  function automatic int lmask(int idx);
    int m = 0;
    for (int g = 0; g < GRAN; g++) if (m_st[idx][g] != 0) m |= (1 << g);
    return m;
  endfunction

  task automatic compare();
    bit ebv;
    chk(alloc_ready == (m_ph == 0), "R2 alloc_ready", alloc_ready, m_ph == 0);
    ebv = (m_ph == 2) && (m_st[m_idx][m_g] != 0);
    chk(binv_valid == ebv, "R3 binv_valid", binv_valid, ebv);
    if (ebv) begin
      chk(binv_gran == m_g, "R3 binv_gran", binv_gran, m_g);
      chk(binv_tag == m_tag[m_idx] && binv_idx == m_idx, "R3 binv_tag", binv_tag, m_tag[m_idx]);
    end
    chk(cb_valid == (m_ph == 4), "R7 cb_valid", cb_valid, m_ph == 4);
    if (m_ph == 4) begin
      chk(cb_mask == dmask(m_idx), "R7 cb_mask", cb_mask, dmask(m_idx));
      chk(cb_tag == m_tag[m_idx] && cb_idx == m_idx, "R7 cb_tag", cb_tag, m_tag[m_idx]);
    end
    chk(fetch_valid == (m_ph == 5), "R8 fetch_valid", fetch_valid, m_ph == 5);
    if (m_ph == 5) begin
      chk(fetch_tag == m_ntag && fetch_idx == m_idx, "R8 fetch_tag", fetch_tag, m_ntag);
      chk(fetch_fill == m_fill, "R8 fetch_fill", fetch_fill, m_fill);
    end
    chk(done == (m_ph == 6), "R9 done", done, m_ph == 6);
    if (fetch_valid && d_fetch_at < 0) d_fetch_at = cyc;
  endtask

  task automatic drive();
    bit rdy;
    rdy = (k_gap == 0) || ((cyc % (k_gap + 1)) == 0);
    alloc_valid = 0;
    if (m_ph == 0 && req_pend) begin
      alloc_valid = 1; alloc_idx = IDX_W'(r_idx); alloc_tag = TAG_W'(r_tag);
      alloc_excl = r_excl[0]; alloc_fill = GRAN'(r_fill);
    end else if (m_ph != 0 && k_noise && (cyc % 2 == 0)) begin
      alloc_valid = 1; alloc_idx = IDX_W'(r_idx + 1); alloc_tag = 8'hEE;
      alloc_excl = 1; alloc_fill = '1;
    end
    binv_ready = rdy; cb_ready = rdy; fetch_ready = rdy;
    resp_valid = 0; resp_push = 0; resp_gran = '0;
    if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
      resp_valid = 1; resp_gran = GW'(rq_g[0]); resp_push = rq_p[0][0];
      void'(rq_due.pop_front()); void'(rq_g.pop_front()); void'(rq_p.pop_front());
    end
    if (binv_valid && binv_ready) d_binv++;
    if (cb_valid && cb_ready) begin d_cb++; d_cbmask = cb_mask; end
  endtask

  task automatic step();
    bit live;
    case (m_ph)
      0: if (alloc_valid) begin
           m_idx = r_idx; m_ntag = r_tag; m_excl = r_excl; m_fill = r_fill;
           req_pend = 0; t_acc = cyc; m_ph = 1;
         end
      1: if (lmask(m_idx) == 0) m_ph = 5;
         else begin m_g = 0; m_iss = 0; m_ans = 0; m_ph = 2; end
      2: begin
           live = m_st[m_idx][m_g] != 0;
           if (live && binv_ready) begin
             m_iss++;
             rq_due.push_back(cyc + k_delay); rq_g.push_back(m_g); rq_p.push_back((k_push >> m_g) & 1);
           end
           if (!live || binv_ready) begin
             if (m_g == GRAN - 1) m_ph = 3; else m_g++;
           end
         end
      3: if (m_iss == m_ans) begin
           if (dmask(m_idx) != 0) m_ph = 4;
           else begin for (int g = 0; g < GRAN; g++) m_st[m_idx][g] = 0; m_ph = 5; end
         end
      4: if (cb_ready) begin
           for (int g = 0; g < GRAN; g++) m_st[m_idx][g] = 0;
           m_ph = 5;
         end
      5: if (fetch_ready) begin
           m_tag[m_idx] = m_ntag;
           for (int g = 0; g < GRAN; g++)
             m_st[m_idx][g] = ((m_fill >> g) & 1) ? (m_excl ? 2 : 1) : 0;
           m_ph = 6;
         end
      6: begin m_ph = 0; scn_done = 1; end
      default: m_ph = 0;
    endcase
    if (resp_valid) begin
      m_ans++;
      if (resp_push) m_st[m_idx][resp_gran] = 3;
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      compare();
      drive();
      step();
      cyc++;
    end
  end

  task automatic alloc(input int idx, input int tag, input int excl, input int fill,
                       input int push, input int gap, input int dly, input bit noise);
    @(posedge clk);
    r_idx = idx; r_tag = tag; r_excl = excl; r_fill = fill;
    k_push = push; k_gap = gap; k_delay = dly; k_noise = noise;
    d_binv = 0; d_cb = 0; d_cbmask = 0; d_fetch_at = -1;
    scn_done = 0; req_pend = 1;
    while (!scn_done && cyc < LIMIT) @(posedge clk);
    if (!scn_done) hung = 1;
    k_noise = 0;
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_tag[s] = 0;
      for (int g = 0; g < GRAN; g++) m_st[s][g] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 alloc_ready after reset", alloc_ready, 1);
    chk({binv_valid, cb_valid, fetch_valid, done} == 4'b0, "R1 requests idle after reset",
        {binv_valid, cb_valid, fetch_valid, done}, 0);
    run = 1;

    // R4: reset entry is Invalid -> straight to fetch two cycles after acceptance
    alloc(3, 'h11, 1, 'hF, 0, 0, 1, 0);
    chk(d_binv == 0, "R4 no back-invalidation on invalid victim", d_binv, 0);
    chk(d_cb == 0, "R4 no copy-back on invalid victim", d_cb, 0);
    chk(d_fetch_at - t_acc == 2, "R4 fetch latency", d_fetch_at - t_acc, 2);
    // R3/R6: exclusive victim, all miss -> four back-invalidations, no copy-back
    if (!hung) alloc(3, 'h22, 0, 'h5, 0, 0, 1, 0);
    chk(d_binv == 4, "R3 one back-invalidation per live granule", d_binv, 4);
    chk(d_cb == 0, "R6 misses leave victim clean", d_cb, 0);
    // R3/R7/R8: shared victim in granules 0,2; push on granule 2
    if (!hung) alloc(3, 'h33, 1, 'hF, 'h4, 0, 2, 0);
    chk(d_binv == 2, "R3 invalid granules skipped", d_binv, 2);
    chk(d_cb == 1 && d_cbmask == 'h4, "R7 copy-back mask after push", d_cbmask, 'h4);
    // R2/R10: slow handshakes, busy-time alloc noise, all granules push back
    if (!hung) alloc(3, 'h44, 1, 'h3, 'hF, 2, 3, 1);
    chk(d_binv == 4, "R10 back-invalidations under stalls", d_binv, 4);
    chk(d_cbmask == 'hF, "R6 every push marks Modified", d_cbmask, 'hF);
    // R8: previous fill 0011 exclusive -> two live granules
    if (!hung) alloc(3, 'h55, 0, 'hF, 0, 0, 1, 0);
    chk(d_binv == 2, "R8 fill mask installed", d_binv, 2);
    chk(d_cb == 0, "R6 clean response leaves no copy-back", d_cb, 0);
    // R7: shared victim, single push on granule 1
    if (!hung) alloc(3, 'h66, 1, 'hF, 'h2, 1, 1, 0);
    chk(d_binv == 4 && d_cbmask == 'h2, "R7 single dirty granule", d_cbmask, 'h2);
    // R4/R8: empty fill leaves an Invalid entry for the next victim
    if (!hung) alloc(6, 'h77, 1, 'h0, 0, 0, 1, 0);
    if (!hung) alloc(6, 'h78, 1, 'hF, 0, 0, 1, 0);
    chk(d_binv == 0 && d_fetch_at - t_acc == 2, "R4 empty-fill entry treated as invalid",
        d_binv, 0);

    if (hung) chk(0, "WATCHDOG", cyc, LIMIT);
    repeat (2) @(posedge clk);
    run = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule